// File: doc/BRIEF.md
# Audio Serial Clock Generator

This block produces the bit clock and the frame (left/right) clock for a serial audio port, separately for the transmit and the receive direction. Each direction has its own master-clock input and its own two-stage divider chain: the first stage divides the master clock down to the bit clock, the second counts bit clocks to form the frame clock. The master clocks reach the block as single-cycle tick strobes in the core clock domain, so the whole block runs on one clock.

Static configuration inputs select master operation (the block drives the clocks) or slave operation (externally supplied bit and frame clocks are passed on), the bit-clock polarity, a per-direction frame-clock polarity, and a sharing mode that lets both directions run from one direction's clock pair. Divider values are picked up only at a frame boundary, so a reconfiguration never produces a short or long pulse in the middle of a frame. The configured frame length is meant to be an even number of bit clocks of at least 32, with 64 as the usual choice.

Top module: `audio_clkgen`

## Requirements
- R1: While reset is held in master mode with separate clocks, each bit clock output equals the bit polarity bit and each frame clock output equals its frame polarity bit; after reset the first frame half is the low (left) half in normal frame sense.
- R2: In master mode the bit period is N master ticks with N = bit divider field + 1 (a field of 0 is treated as 1, so N = 2); within a period the normal-sense bit clock is low for ceil(N/2) ticks and high for floor(N/2) ticks.
- R3: The frame clock toggles every H bit periods with H = (frame divider field + 1) / 2 (at least 1), and each toggle happens in the same cycle as the bit-clock falling edge (normal sense) that ends a bit.
- R4: The bit polarity input at 1 inverts both bit clock outputs, so the frame clock toggles together with a rising bit clock edge.
- R5: Each frame polarity input at 1 inverts only its own direction's frame clock output.
- R6: A divider field change made in the middle of a frame leaves the rest of that frame at the old values; the new values apply from the next frame start (frame clock returning to the left half).
- R7: With the slave select at 1 the outputs follow the external bit and frame clock inputs (through the polarity bits) and the internal dividers stay still; returning to master restarts the chain at the start of a left half with the bit clock low.
- R8: Sharing field 0 or 3 gives independent clocks, 1 drives both directions from the transmit chain (transmit input in slave mode), 2 drives both from the receive chain.
- R9: A bit clock in master mode changes only in the cycle after its own direction's master tick; with ticks every other cycle every interval doubles.
- R10: Transmit and receive dividers are independent: different settings yield different periods on the two outputs at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tx_mclk_tick | input | 1 | Transmit master clock strobe, one per master period |
| rx_mclk_tick | input | 1 | Receive master clock strobe |
| cfg_slave | input | 1 | 0 master (generate clocks), 1 slave (pass external clocks) |
| cfg_bclk_inv | input | 1 | 0 normal bit-clock sense, 1 inverted |
| cfg_share | input | 2 | 0/3 separate, 1 both use transmit clocks, 2 both use receive clocks |
| cfg_tx_bdiv | input | DIV_W | Transmit master-to-bit ratio minus one |
| cfg_rx_bdiv | input | DIV_W | Receive master-to-bit ratio minus one |
| cfg_tx_fdiv | input | DIV_W | Transmit bit clocks per frame minus one |
| cfg_rx_fdiv | input | DIV_W | Receive bit clocks per frame minus one |
| cfg_tx_lrinv | input | 1 | Transmit frame clock opposite sense |
| cfg_rx_lrinv | input | 1 | Receive frame clock opposite sense |
| ext_tx_bclk | input | 1 | External transmit bit clock (slave) |
| ext_tx_lrck | input | 1 | External transmit frame clock (slave) |
| ext_rx_bclk | input | 1 | External receive bit clock (slave) |
| ext_rx_lrck | input | 1 | External receive frame clock (slave) |
| tx_bclk | output | 1 | Transmit bit clock |
| tx_lrck | output | 1 | Transmit frame clock |
| rx_bclk | output | 1 | Receive bit clock |
| rx_lrck | output | 1 | Receive frame clock |

## Verification
The hardest situation to reach is a divider change landing in the middle of a frame, because the effect is only visible as the length of the half frame after the change compared with the one after the next boundary. The stimulus waits for the frame clock to enter the right half, alters both divider fields in that cycle, and then times the two following half frames in core cycles, expecting the old length and then the new one. Slave-to-master re-entry and the sharing modes are reached by changing the static inputs while ticks keep running, and the tick rate itself is halved to show that every interval scales with the master clock.

// File: rtl/audio_clkgen.sv
module audio_clkgen #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tx_mclk_tick,
  input  logic             rx_mclk_tick,
  input  logic             cfg_slave,
  input  logic             cfg_bclk_inv,
  input  logic [1:0]       cfg_share,
  input  logic [DIV_W-1:0] cfg_tx_bdiv,
  input  logic [DIV_W-1:0] cfg_rx_bdiv,
  input  logic [DIV_W-1:0] cfg_tx_fdiv,
  input  logic [DIV_W-1:0] cfg_rx_fdiv,
  input  logic             cfg_tx_lrinv,
  input  logic             cfg_rx_lrinv,
  input  logic             ext_tx_bclk,
  input  logic             ext_tx_lrck,
  input  logic             ext_rx_bclk,
  input  logic             ext_rx_lrck,
  output logic             tx_bclk,
  output logic             tx_lrck,
  output logic             rx_bclk,
  output logic             rx_lrck
);

  localparam int CW = DIV_W + 1;
  localparam logic [CW-1:0] MIN_RATIO = CW'(2);
  localparam logic [1:0] SHARE_TX = 2'd1;
  localparam logic [1:0] SHARE_RX = 2'd2;

  logic [1:0]            tick_v;
  logic [1:0][DIV_W-1:0] bdiv_in;
  logic [1:0][DIV_W-1:0] fdiv_in;
  logic [1:0]            int_b;
  logic [1:0]            int_l;
  logic [1:0]            src_b;
  logic [1:0]            src_l;

  assign tick_v  = {rx_mclk_tick, tx_mclk_tick};
  assign bdiv_in = {cfg_rx_bdiv, cfg_tx_bdiv};
  assign fdiv_in = {cfg_rx_fdiv, cfg_tx_fdiv};

  for (genvar d = 0; d < 2; d++) begin : g_dir
    logic [DIV_W-1:0] bdiv_q, fdiv_q, mcnt, bcnt;
    logic             bclk_q, lr_q, armed;
    logic [CW-1:0]    ratio, last, lowlen, hbits, hlast, mcnt_n;
    logic             bit_end, half_end;

    assign ratio    = (bdiv_q == '0) ? MIN_RATIO : {1'b0, bdiv_q} + CW'(1);
    assign last     = ratio - CW'(1);
    assign lowlen   = (ratio + CW'(1)) >> 1;
    assign hbits    = ({1'b0, fdiv_q} + CW'(1)) >> 1;
    assign hlast    = (hbits == '0) ? '0 : hbits - CW'(1);
    assign bit_end  = ({1'b0, mcnt} == last);
    assign half_end = bit_end && ({1'b0, bcnt} == hlast);
    assign mcnt_n   = bit_end ? '0 : {1'b0, mcnt} + CW'(1);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        bdiv_q <= '0;
        fdiv_q <= '0;
        mcnt   <= '0;
        bcnt   <= '0;
        bclk_q <= 1'b0;
        lr_q   <= 1'b0;
        armed  <= 1'b0;
      end else if (cfg_slave) begin
        mcnt   <= '0;
        bcnt   <= '0;
        bclk_q <= 1'b0;
        lr_q   <= 1'b0;
        armed  <= 1'b0;
      end else if (tick_v[d]) begin
        if (!armed) begin
          armed  <= 1'b1;
          bdiv_q <= bdiv_in[d];
          fdiv_q <= fdiv_in[d];
        end else begin
          mcnt   <= mcnt_n[DIV_W-1:0];
          bclk_q <= (mcnt_n >= lowlen);
          if (half_end) begin
            bcnt <= '0;
            lr_q <= ~lr_q;
            if (lr_q) begin
              bdiv_q <= bdiv_in[d];
              fdiv_q <= fdiv_in[d];
            end
          end else if (bit_end) begin
            bcnt <= bcnt + DIV_W'(1);
          end
        end
      end
    end

    assign int_b[d] = bclk_q;
    assign int_l[d] = lr_q;
  end

  assign src_b = cfg_slave ? {ext_rx_bclk, ext_tx_bclk} : int_b;
  assign src_l = cfg_slave ? {ext_rx_lrck, ext_tx_lrck} : int_l;

  logic tx_sel, rx_sel;
  assign tx_sel = (cfg_share == SHARE_RX);
  assign rx_sel = (cfg_share != SHARE_TX);

  assign tx_bclk = src_b[tx_sel] ^ cfg_bclk_inv;
  assign rx_bclk = src_b[rx_sel] ^ cfg_bclk_inv;
  assign tx_lrck = src_l[tx_sel] ^ cfg_tx_lrinv;
  assign rx_lrck = src_l[rx_sel] ^ cfg_rx_lrinv;

endmodule

// File: rtl/audio_clkgen_chk.sv
module audio_clkgen_chk #(
  parameter int DIV_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tx_mclk_tick,
  input logic             cfg_slave,
  input logic             cfg_bclk_inv,
  input logic [1:0]       cfg_share,
  input logic             cfg_tx_lrinv,
  input logic             cfg_rx_lrinv,
  input logic             ext_tx_bclk,
  input logic             ext_tx_lrck,
  input logic             tx_bclk,
  input logic             tx_lrck,
  input logic             rx_bclk,
  input logic             rx_lrck
);

  logic steady;
  assign steady = 1'b1;

  assert_lr_on_bit_edge_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_slave && $stable(cfg_slave) && $stable(cfg_share) && $stable(cfg_bclk_inv)
     && $stable(cfg_tx_lrinv) && !$stable(tx_lrck)) |-> !$stable(tx_bclk));

  assert_share_tx_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_share == 2'd1) |-> (rx_bclk == tx_bclk) &&
                            ((rx_lrck ^ cfg_rx_lrinv) == (tx_lrck ^ cfg_tx_lrinv)));

  assert_bclk_needs_tick_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_slave && $stable(cfg_slave) && cfg_share == 2'd0 && $stable(cfg_share)
     && $stable(cfg_bclk_inv) && !$past(tx_mclk_tick)) |-> $stable(tx_bclk));

  assert_slave_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_slave && $stable(cfg_slave) && cfg_share == 2'd0 && $stable(cfg_share)
     && $stable(cfg_bclk_inv) && $stable(cfg_tx_lrinv) && $stable(ext_tx_bclk)
     && $stable(ext_tx_lrck)) |-> ($stable(tx_bclk) && $stable(tx_lrck)));

  always @(posedge clk) begin
    if (steady && !rst_n && !cfg_slave && cfg_share == 2'd0)
      assert_reset_idle_R1: assert (tx_bclk == cfg_bclk_inv && tx_lrck == cfg_tx_lrinv);
  end

endmodule

bind audio_clkgen audio_clkgen_chk #(.DIV_W(DIV_W)) u_chk (.*);

// File: tb/tb_audio_clkgen.sv
`timescale 1ns/1ps
module tb_audio_clkgen;
  localparam int DIV_W = 8;
  localparam int NV = 6;
  localparam logic [15:0] VEC [NV] = '{16'h011F, 16'h021F, 16'h033F,
                                       16'h001F, 16'h0621, 16'h0407};

  logic clk = 0, rst_n = 0;
  logic tx_tick = 0, rx_tick = 0;
  logic cfg_slave = 0, cfg_bclk_inv = 0, cfg_tx_lrinv = 0, cfg_rx_lrinv = 0;
  logic [1:0] cfg_share = 0;
  logic [DIV_W-1:0] cfg_tx_bdiv = 8'd1, cfg_rx_bdiv = 8'd1;
  logic [DIV_W-1:0] cfg_tx_fdiv = 8'd31, cfg_rx_fdiv = 8'd31;
  logic ext_tx_bclk = 0, ext_tx_lrck = 0, ext_rx_bclk = 0, ext_rx_lrck = 0;
  logic tx_bclk, tx_lrck, rx_bclk, rx_lrck;
  int tx_mode = 0, rx_mode = 0;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  audio_clkgen #(.DIV_W(DIV_W)) dut (
    .clk(clk), .rst_n(rst_n), .tx_mclk_tick(tx_tick), .rx_mclk_tick(rx_tick),
    .cfg_slave(cfg_slave), .cfg_bclk_inv(cfg_bclk_inv), .cfg_share(cfg_share),
    .cfg_tx_bdiv(cfg_tx_bdiv), .cfg_rx_bdiv(cfg_rx_bdiv),
    .cfg_tx_fdiv(cfg_tx_fdiv), .cfg_rx_fdiv(cfg_rx_fdiv),
    .cfg_tx_lrinv(cfg_tx_lrinv), .cfg_rx_lrinv(cfg_rx_lrinv),
    .ext_tx_bclk(ext_tx_bclk), .ext_tx_lrck(ext_tx_lrck),
    .ext_rx_bclk(ext_rx_bclk), .ext_rx_lrck(ext_rx_lrck),
    .tx_bclk(tx_bclk), .tx_lrck(tx_lrck), .rx_bclk(rx_bclk), .rx_lrck(rx_lrck));

  always #10 clk = ~clk;

  initial begin
    bit tg = 0;
    forever begin
      @(negedge clk);
      tg = ~tg;
      tx_tick = (tx_mode == 1) || (tx_mode == 2 && tg);
      rx_tick = (rx_mode == 1) || (rx_mode == 2 && tg);
    end
  end

  initial begin
    #(20 * 150000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int ex_n(input int b);  return (b == 0) ? 2 : b + 1; endfunction
  function automatic int ex_h(input int f);  return ((f + 1) / 2 < 1) ? 1 : (f + 1) / 2; endfunction
  function automatic bit gb(input bit rx); return rx ? rx_bclk : tx_bclk; endfunction
  function automatic bit gl(input bit rx); return rx ? rx_lrck : tx_lrck; endfunction

  task automatic do_reset();
    tx_mode = 0; rx_mode = 0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
  endtask

  // waits for a frame clock change; returns bit clock before and at that sample
  task automatic wait_lr(input bit rx, output bit pb, output bit cb, output bit ok);
    bit pl = gl(rx);
    pb = gb(rx);
    ok = 0;
    for (int i = 0; i < 5000; i++) begin
      @(negedge clk);
      if (gl(rx) != pl) begin cb = gb(rx); ok = 1; return; end
      pb = gb(rx);
    end
    cb = pb;
  endtask

  task automatic measure(input bit rx, output int lo, output int hi, output int half, output bit aligned);
    bit pb, cb, ok, b0;
    int ph;
    lo = -1; hi = -1; half = -1; aligned = 0;
    wait_lr(rx, pb, cb, ok);
    if (!ok) return;
    aligned = (pb != cb) && (cb == cfg_bclk_inv);
    b0 = cb; lo = 1; hi = 0; ph = 0;
    begin
      bit pl = gl(rx);
      for (int c = 1; c < 5000; c++) begin
        @(negedge clk);
        if (gl(rx) != pl) begin half = c; return; end
        if (ph == 0) begin
          if (gb(rx) == b0) lo++; else begin ph = 1; hi = 1; end
        end else if (ph == 1) begin
          if (gb(rx) != b0) hi++; else ph = 2;
        end
      end
    end
  endtask

  task automatic half_len(input bit rx, output int half);
    bit pb, cb, ok;
    half = -1;
    wait_lr(rx, pb, cb, ok);
    if (!ok) return;
    wait_lr(rx, pb, cb, ok);
    if (!ok) return;
    // second call counted from previous edge; recount directly
  endtask

  task automatic count_half(input bit rx, output int half);
    bit pl = gl(rx);
    half = -1;
    for (int c = 1; c < 5000; c++) begin
      @(negedge clk);
      if (gl(rx) != pl) begin half = c; return; end
    end
  endtask

  initial begin
    int lo, hi, half, n, h, b, f;
    bit al, pb, cb, ok, same;

    // R1: reset state
    rst_n = 0;
    repeat (2) @(negedge clk);
    chk(tx_bclk == 0 && rx_bclk == 0, "R1 bclk in reset", {tx_bclk, rx_bclk}, 0);
    chk(tx_lrck == 0 && rx_lrck == 0, "R1 lrck in reset", {tx_lrck, rx_lrck}, 0);
    rst_n = 1;
    tx_mode = 1;
    wait_lr(0, pb, cb, ok);
    chk(ok && tx_lrck == 1, "R1 first half is left (lrck low then rises)", tx_lrck, 1);

    // R2 R3 R10: vector table, tx and rx with different settings
    for (int k = 0; k < NV; k++) begin
      do_reset();
      cfg_tx_bdiv = VEC[k][15:8];           cfg_tx_fdiv = VEC[k][7:0];
      cfg_rx_bdiv = VEC[(k + 1) % NV][15:8]; cfg_rx_fdiv = VEC[(k + 1) % NV][7:0];
      tx_mode = 1; rx_mode = 1;
      for (int d = 0; d < 2; d++) begin
        b = (d == 0) ? int'(cfg_tx_bdiv) : int'(cfg_rx_bdiv);
        f = (d == 0) ? int'(cfg_tx_fdiv) : int'(cfg_rx_fdiv);
        n = ex_n(b); h = ex_h(f);
        measure(d[0], lo, hi, half, al);
        chk(lo == (n + 1) / 2 && hi == n / 2, "R2 bit low/high phases",
            lo * 1000 + hi, ((n + 1) / 2) * 1000 + n / 2);
        chk(half == n * h, "R3 R10 half frame length", half, n * h);
        chk(al, "R3 frame edge on bit falling edge", al, 1);
      end
    end

    // R4: inverted bit clock
    do_reset();
    cfg_tx_bdiv = 8'd2; cfg_tx_fdiv = 8'd31; cfg_bclk_inv = 1;
    tx_mode = 1;
    measure(0, lo, hi, half, al);
    chk(al, "R4 frame edge on inverted (rising) bit edge", al, 1);
    chk(lo == 2 && hi == 1, "R4 inverted phases", lo * 1000 + hi, 2001);
    cfg_bclk_inv = 0;

    // R5: per-direction frame polarity
    cfg_tx_lrinv = 1;
    do_reset();
    @(negedge clk);
    chk(tx_lrck == 1 && rx_lrck == 0, "R5 only tx frame clock inverted", {tx_lrck, rx_lrck}, 2);
    tx_mode = 1;
    wait_lr(0, pb, cb, ok);
    chk(ok && tx_lrck == 0, "R5 inverted first toggle goes low", tx_lrck, 0);
    cfg_tx_lrinv = 0;

    // R6: divider change mid-frame
    do_reset();
    cfg_tx_bdiv = 8'd1; cfg_tx_fdiv = 8'd31;
    tx_mode = 1;
    ok = 0;
    for (int i = 0; i < 2000 && !ok; i++) begin
      pb = tx_lrck;
      @(negedge clk);
      if (!pb && tx_lrck) ok = 1;
    end
    cfg_tx_bdiv = 8'd3; cfg_tx_fdiv = 8'd23;
    count_half(0, half);
    chk(half == 32, "R6 rest of frame keeps old dividers", half, 32);
    count_half(0, half);
    chk(half == 48, "R6 new dividers from next frame", half, 48);

    // R9: tick gating and half-rate ticks
    do_reset();
    cfg_tx_bdiv = 8'd1; cfg_tx_fdiv = 8'd31;
    tx_mode = 2;
    wait_lr(0, pb, cb, ok);
    count_half(0, half);
    chk(half == 64, "R9 half-rate ticks double the half frame", half, 64);
    tx_mode = 0;
    @(negedge clk);
    cb = tx_bclk; same = 1;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (tx_bclk != cb) same = 0;
    end
    chk(same, "R9 bit clock frozen without ticks", same, 1);

    // R7: slave pass-through
    tx_mode = 1; rx_mode = 1;
    cfg_slave = 1;
    ext_tx_bclk = 1; ext_tx_lrck = 0; ext_rx_bclk = 0; ext_rx_lrck = 1;
    @(negedge clk); #1;
    chk(tx_bclk == 1 && tx_lrck == 0 && rx_bclk == 0 && rx_lrck == 1, "R7 slave follows external",
        {tx_bclk, tx_lrck, rx_bclk, rx_lrck}, 4'b1001);
    cfg_bclk_inv = 1;
    #1;
    chk(tx_bclk == 0 && rx_bclk == 1, "R7 slave with bit polarity", {tx_bclk, rx_bclk}, 1);
    cfg_bclk_inv = 0;
    same = 1;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (tx_bclk != 1 || tx_lrck != 0) same = 0;
    end
    chk(same, "R7 no internal clocks in slave mode", same, 1);
    cfg_slave = 0;
    @(negedge clk);
    chk(tx_bclk == 0 && tx_lrck == 0, "R7 master restart at left half", {tx_bclk, tx_lrck}, 0);
    wait_lr(0, pb, cb, ok);
    chk(ok && tx_lrck == 1, "R7 first toggle after restart rises", tx_lrck, 1);

    // R8: sharing modes
    do_reset();
    cfg_tx_bdiv = 8'd1; cfg_tx_fdiv = 8'd31; cfg_rx_bdiv = 8'd6; cfg_rx_fdiv = 8'd33;
    tx_mode = 1; rx_mode = 1;
    cfg_share = 2'd1;
    same = 1;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      if (rx_bclk != tx_bclk || rx_lrck != tx_lrck) same = 0;
    end
    chk(same, "R8 share=1 rx equals tx", same, 1);
    wait_lr(1, pb, cb, ok);
    count_half(1, half);
    chk(half == 32, "R8 share=1 rx uses tx dividers", half, 32);
    cfg_share = 2'd2;
    wait_lr(0, pb, cb, ok);
    count_half(0, half);
    chk(half == 119, "R8 share=2 tx uses rx dividers", half, 119);
    cfg_share = 2'd3;
    wait_lr(0, pb, cb, ok);
    count_half(0, half);
    chk(half == 32, "R8 share=3 separate clocks", half, 32);
    cfg_share = 2'd0;

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule